// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The host offers one single-beat read or write at a time over a valid/ready handshake. The controller turns each request into a sequence of chip-select, output-enable and write-enable levels. Each phase lasts long enough to meet the memory's access, pulse, setup and float times. Returned read bytes come back on a one-cycle response strobe.

Every phase length is a whole number of clock cycles. Each one is the ceiling of a nanosecond parameter divided by the clock period, and any nonzero requirement gets at least one cycle. Both chip selects (one active low, one active high) always move together. A write is terminated by write enable rising while the chip stays selected one more cycle, so data hold is met. The bidirectional data bus appears as separate out, in and drive-enable signals. A change of transfer direction inserts idle turnaround cycles so the controller and the memory never drive the bus at the same time.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and while no access is in progress the memory pins rest at memCe1n=1, memCe2=0, memWen=1, memOen=1, memDqOe=0, and reqReady=1, rspValid=0.
- R2: memCe1n is always the inverse of memCe2, and the chip is deselected for at least one cycle between any two accesses.
- R3: A read selects the chip with memWen=1 and memOen=0 for exactly NRD cycles, where NRD = max(ceil(tAA), ceil(tOE), ceil(tRC)) in clock cycles (2 at the defaults). memDqIn is captured at the end of the last of those cycles. rspValid is high for exactly one cycle, NRD+2 cycles after the accept cycle when no turnaround is inserted.
- R4: A write holds memWen=0 for exactly NWP cycles (2 at the defaults), with memOen=1 and the chip selected throughout. Write enable rises first, the chip stays selected one further cycle, then it is deselected.
- R5: memDqOe is high only during the write-enable-low cycles after the first NWZ of them (NWZ=1 at the defaults) and during the one cycle after write enable rises; while it is high memDqOut equals the accepted write data.
- R6: When an access is in the opposite direction from the previous one, NTURN idle cycles (1 at the defaults) are added before the chip is selected, so selection starts 2+NTURN cycles after the accept cycle; otherwise it starts 2 cycles after. The direction history starts as read after reset.
- R7: memAddr equals the accepted request address in every cycle the chip is selected.
- R8: A request is accepted only in a cycle where reqReady is high. A valid held while reqReady is low has no effect, so each request produces exactly one chip-select episode.
- R9: A read returns the byte most recently written to the same address through the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 8 | Read data |
| memAddr | output | 17 | Memory address bus |
| memCe1n | output | 1 | Chip select, active low |
| memCe2 | output | 1 | Chip select, active high |
| memOen | output | 1 | Output enable, active low |
| memWen | output | 1 | Write enable, active low |
| memDqOut | output | 8 | Data to the memory |
| memDqOe | output | 1 | Controller drives the data bus |
| memDqIn | input | 8 | Data from the memory |

## Verification
The hardest cases to reach from the ports are a new request that is already waiting while the previous access is still on the pins, and a direction change that must insert turnaround. The bench reaches them by starting each request the moment the previous one has begun. The request valid then sits high through the busy cycles. Directions and addresses are drawn at random, with directed runs of back-to-back writes, back-to-back reads and strict alternation at the lowest and highest addresses. A memory model returns unknown data until the select and output-enable levels have been held for the required cycles. It commits a write only when write enable rises, so a short phase or early capture shows up as wrong read data.

// File: rtl/asram_ctrl_pkg.sv
`timescale 1ns/1ps
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD
  } ctrlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request address and data
    logic sel;      // chip selected
    logic rdEn;     // output enable asserted
    logic wrEn;     // write enable asserted
    logic drive;    // controller drives data bus
    logic capture;  // last read cycle, sample bus
  } strobeT;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling of ns over the clock period, zero for a zero requirement
  function automatic int nsToCycles(input int ns, input int period);
    return (ns <= 0) ? 0 : (ns + period - 1) / period;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int N_RD   = 2,
  parameter int N_WP   = 2,
  parameter int N_WZ   = 1,
  parameter int N_TURN = 1,
  parameter int CNT_W  = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output strobeT strb
);

  ctrlStateT state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic lastWr, lastWrN;
  logic pendWr, pendWrN;

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(N_TURN - 1);
  localparam logic [CNT_W-1:0] WZ_CNT    = CNT_W'(N_WZ);

  always_comb begin
    stateN  = state;
    cntN    = cnt;
    lastWrN = lastWr;
    pendWrN = pendWr;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          pendWrN = reqWrite;
          lastWrN = reqWrite;
          cntN    = '0;
          if (reqWrite != lastWr) stateN = ST_TURN;
          else                    stateN = reqWrite ? ST_WPULSE : ST_READ;
        end
      end
      ST_TURN: begin
        if (cnt == TURN_LAST) begin
          cntN   = '0;
          stateN = pendWr ? ST_WPULSE : ST_READ;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          cntN   = '0;
          stateN = ST_IDLE;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      ST_WPULSE: begin
        if (cnt == WP_LAST) begin
          cntN   = '0;
          stateN = ST_WHOLD;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      ST_WHOLD: stateN = ST_IDLE;
      default:  stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      lastWr <= 1'b0;
      pendWr <= 1'b0;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      lastWr <= lastWrN;
      pendWr <= pendWrN;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.sel     = (state == ST_READ) || (state == ST_WPULSE) || (state == ST_WHOLD);
    strb.rdEn    = (state == ST_READ);
    strb.wrEn    = (state == ST_WPULSE);
    strb.drive   = ((state == ST_WPULSE) && (cnt >= WZ_CNT)) || (state == ST_WHOLD);
    strb.capture = (state == ST_READ) && (cnt == RD_LAST);
  end

  // idle with no request stays idle
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !reqValid) |=> (state == ST_IDLE));

  // a write pulse is always followed by the hold cycle
  assert_hold_after_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WPULSE && cnt == WP_LAST) |=> (state == ST_WHOLD));

endmodule

// File: rtl/asram_ctrl_dp.sv
`timescale 1ns/1ps
module asram_ctrl_dp
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1n,
  output logic              memCe2,
  output logic              memOen,
  output logic              memWen,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              captureQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  // pin registers, glitch free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCe1n  <= 1'b1;
      memCe2   <= 1'b0;
      memOen   <= 1'b1;
      memWen   <= 1'b1;
      memDqOe  <= 1'b0;
      captureQ <= 1'b0;
    end else begin
      memCe1n  <= !strb.sel;
      memCe2   <= strb.sel;
      memOen   <= !strb.rdEn;
      memWen   <= !strb.wrEn;
      memDqOe  <= strb.drive;
      captureQ <= strb.capture;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= captureQ;
      if (captureQ) rspData <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;

  assert_ce_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    memCe1n == !memCe2);

  assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWen |-> (memOen && !memCe1n));

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWen || $past(!memWen)));

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memOen |-> !memDqOe);

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1n && $past(!memCe1n)) |-> $stable(memAddr));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_OE_NS       = 6,
  parameter int T_WC_NS       = 10,
  parameter int T_WP_NS       = 8,
  parameter int T_AW_NS       = 8,
  parameter int T_DW_NS       = 5,
  parameter int T_WHZ_NS      = 5,
  parameter int T_OHZ_NS      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1n,
  output logic              memCe2,
  output logic              memOen,
  output logic              memWen,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int C_RC  = nsToCycles(T_RC_NS,  CLK_PERIOD_NS);
  localparam int C_AA  = nsToCycles(T_AA_NS,  CLK_PERIOD_NS);
  localparam int C_OE  = nsToCycles(T_OE_NS,  CLK_PERIOD_NS);
  localparam int C_WC  = nsToCycles(T_WC_NS,  CLK_PERIOD_NS);
  localparam int C_WP  = nsToCycles(T_WP_NS,  CLK_PERIOD_NS);
  localparam int C_AW  = nsToCycles(T_AW_NS,  CLK_PERIOD_NS);
  localparam int C_DW  = nsToCycles(T_DW_NS,  CLK_PERIOD_NS);
  localparam int C_WHZ = nsToCycles(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int C_OHZ = nsToCycles(T_OHZ_NS, CLK_PERIOD_NS);

  localparam int N_RD   = imax(imax(1, C_AA), imax(C_OE, C_RC));
  localparam int N_WZ   = imax(1, C_WHZ);
  // pulse covers width, address window, float plus data setup, cycle time less hold
  localparam int N_WP   = imax(imax(C_WP, C_AW), imax(N_WZ + imax(1, C_DW), C_WC - 1));
  localparam int N_TURN = imax(1, C_OHZ);
  localparam int CNT_W  = $clog2(imax(imax(N_RD, N_WP), N_TURN) + 1);

  strobeT strb;

  asram_ctrl_fsm #(
    .N_RD   (N_RD),
    .N_WP   (N_WP),
    .N_WZ   (N_WZ),
    .N_TURN (N_TURN),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strb     (strb)
  );

  asram_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memCe1n  (memCe1n),
    .memCe2   (memCe2),
    .memOen   (memOen),
    .memWen   (memWen),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

  localparam int TCLK_NS = 5;
  localparam int AW = 17;
  localparam int DW = 8;

  function automatic int cdiv(input int ns);
    return (ns + TCLK_NS - 1) / TCLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from the requirement timings
  localparam int NRD   = mx(mx(cdiv(10), cdiv(6)), cdiv(10));
  localparam int NWZ   = mx(1, cdiv(5));
  localparam int NWP   = mx(mx(cdiv(8), cdiv(8)), mx(NWZ + cdiv(5), cdiv(10) - 1));
  localparam int NTURN = mx(1, cdiv(4));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic rspValid;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  logic memCe1n, memCe2, memOen, memWen, memDqOe;
  logic [DW-1:0] memDqOut;
  logic [DW-1:0] memDqIn = 'x;

  always #(TCLK_NS / 2.0) clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(TCLK_NS)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCe1n(memCe1n), .memCe2(memCe2), .memOen(memOen), .memWen(memWen),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] modelMem [int];
  logic [DW-1:0] shadow [int];
  logic [AW-1:0] expAddr = '0;
  logic [DW-1:0] expData = '0;
  logic lastWr = 1'b0;
  int nReq = 0;
  int ceRises = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rdModel(input logic [AW-1:0] a);
    return modelMem.exists(int'(a)) ? modelMem[int'(a)] : '0;
  endfunction
  function automatic logic [DW-1:0] rdShadow(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
  endfunction

  // pin monitor and memory model, all on the falling edge
  int weLowCnt = 0, oeLowCnt = 0, rdAge = 0;
  bit prevWeLow = 0, prevOeLow = 0, prevCeAct = 0, ceMustDrop = 0, prevRsp = 0;
  logic [DW-1:0] latched = '0;

  always @(negedge clk) begin
    if (rstN) begin
      bit ceAct, weLow, oeLow, expDrv, rdCond;
      ceAct = !memCe1n;
      weLow = !memWen;
      oeLow = !memOen;
      if (memCe1n != !memCe2) chk(0, "R2 select pair", {memCe1n, memCe2}, 2'b10);
      if (ceMustDrop) begin
        chk(!ceAct, "R4 deselect after hold", ceAct, 0);
        ceMustDrop = 0;
      end
      if (ceAct && !prevCeAct) ceRises++;
      if (ceAct && memAddr != expAddr) chk(0, "R7 address", memAddr, expAddr);
      if (weLow) weLowCnt++;
      expDrv = (weLow && weLowCnt > NWZ) || (!weLow && prevWeLow);
      if (memDqOe != expDrv) chk(0, "R5 drive window", memDqOe, expDrv);
      if (memDqOe && memDqOut != expData) chk(0, "R5 drive data", memDqOut, expData);
      if (weLow && (!memOen || !ceAct)) chk(0, "R4 levels in write", {memOen, ceAct}, 2'b11);
      if (weLow && memDqOe) latched = memDqOut;
      if (!weLow && prevWeLow) begin
        chk(weLowCnt == NWP, "R4 write pulse width", weLowCnt, NWP);
        chk(ceAct, "R4 select held past write enable", ceAct, 1);
        modelMem[int'(memAddr)] = latched;
        weLowCnt = 0;
        ceMustDrop = 1;
      end
      if (oeLow) begin
        oeLowCnt++;
        if (!memWen == 1'b1 || !ceAct) chk(0, "R3 levels in read", {memWen, ceAct}, 2'b11);
      end
      if (!oeLow && prevOeLow) begin
        chk(oeLowCnt == NRD, "R3 read phase length", oeLowCnt, NRD);
        oeLowCnt = 0;
      end
      rdCond = ceAct && oeLow && !weLow;
      rdAge = rdCond ? rdAge + 1 : 0;
      memDqIn <= (rdCond && rdAge >= NRD) ? rdModel(memAddr) : 'x;
      if (rspValid && prevRsp) chk(0, "R3 response single pulse", 1, 0);
      prevRsp = rspValid;
      prevWeLow = weLow;
      prevOeLow = oeLow;
      prevCeAct = ceAct;
    end
  end

  task automatic checkIdle(input string tag);
    chk(memCe1n && !memCe2 && memWen && memOen && !memDqOe && reqReady && !rspValid,
        tag, {memCe1n, memCe2, memWen, memOen, memDqOe, reqReady, rspValid}, 7'b1011010);
  endtask

  task automatic doReq(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int cyc, turn;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = w;
    reqAddr  = a;
    reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = '1;
    reqWdata = '1;
    expAddr  = a;
    expData  = d;
    nReq++;
    turn = (w != lastWr) ? NTURN : 0;
    lastWr = w;
    if (w) shadow[int'(a)] = d;
    cyc = 1;
    while (memCe1n && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 2 + turn, w ? "R6 select delay write" : "R6 select delay read", cyc, 2 + turn);
    if (!w) begin
      while (!rspValid && cyc < 50) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc == NRD + 2 + turn, "R3 response latency", cyc, NRD + 2 + turn);
      chk(rspData == rdShadow(a), "R9 read data", rspData, rdShadow(a));
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finishRun();
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 reset levels");

    // directed: extremes, back-to-back and alternation
    doReq(1, '0, 8'hA5);
    doReq(1, '1, 8'h3C);
    doReq(0, '0, 8'h00);
    doReq(0, '1, 8'h00);
    doReq(1, 17'h00001, 8'hFF);
    doReq(0, 17'h00001, 8'h00);
    doReq(1, 17'h00001, 8'h00);
    doReq(0, 17'h00001, 8'h00);
    repeat (4) @(negedge clk);
    checkIdle("R1 idle levels");

    for (int i = 0; i < 400; i++) begin
      bit w;
      logic [AW-1:0] a;
      int sel;
      w = $urandom_range(0, 1) == 1;
      sel = $urandom_range(0, 9);
      if (sel == 0)      a = '0;
      else if (sel == 1) a = '1;
      else if (sel < 8)  a = AW'($urandom_range(0, 15));
      else               a = AW'($urandom);
      doReq(w, a, DW'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        repeat ($urandom_range(3, 6)) @(negedge clk);
        checkIdle("R1 idle gap levels");
      end
    end

    // final read-back of the small window
    for (int k = 0; k < 16; k++) doReq(0, AW'(k), 8'h00);
    repeat (6) @(negedge clk);
    checkIdle("R1 final idle");
    chk(ceRises == nReq, "R8 one select episode per request", ceRises, nReq);
    done = 1;
    finishRun();
  end

endmodule